// File: doc/BRIEF.md
# Multilevel Priority Interrupt Controller

This block arbitrates a parameterised set of interrupt request lines for a CPU. Each line has its own enable and a two-bit level code (off, low, medium or high). A separate non-maskable request sits above every maskable level. On each cycle the block picks the most urgent pending request that may preempt the handlers already running. It then raises a one-cycle take strobe to the CPU together with the word address of the vector for that source.

The block tracks nesting through four in-service flags, one per level plus one for the non-maskable source. The CPU pulses a return input when a handler finishes, and this clears the innermost active level. Three level-enable bits and a global enable gate the maskable requests. The low level can switch from fixed lowest-index-first order to a rotating order, so that no low-level source is starved.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, `take` is 0, `in_service` is 0000 and no grant is pending.
- R2: A maskable line i is eligible only when all of the following hold: `irq_req[i]` is 1, `irq_en[i]` is 1, its level code `irq_lvl[2i+1:2i]` is nonzero (0 = off, 1 = low, 2 = medium, 3 = high), the matching `lvl_en` bit is set (bit 0 low, bit 1 medium, bit 2 high), and `glb_en` is 1.
- R3: A maskable request is granted only if its level is strictly higher than every level flagged in `in_service` (bit 0 low, bit 1 medium, bit 2 high, bit 3 non-maskable). Medium preempts low, high preempts medium and low, and an equal or lower level waits.
- R4: Among eligible requests of the winning level, the lowest line index is granted (fixed order). This holds for medium and high always, and for low when rotation is off.
- R5: With `rr_en` set, the low-level search starts just after the last granted low-level line and wraps around, so the line served most recently ranks lowest.
- R6: Clearing `rr_en` forgets the stored low-level line. The next low grant, even after `rr_en` is set again, uses the fixed lowest-index order.
- R7: `nmi_req` is granted whenever the non-maskable flag is clear, regardless of `glb_en` and `lvl_en`, and it ranks above all maskable levels. Its vector address is 0x002.
- R8: The vector address for maskable line i is (i+2)*STRIDE, with STRIDE=2 by default. Address 0 is left for reset.
- R9: A grant decided from inputs seen at one clock edge makes `take` high for exactly one cycle after that edge. At the same edge the block updates `vec_addr` and sets the in-service bit of the granted level.
- R10: A `reti` pulse clears the highest set in-service flag, checking the non-maskable flag first, then high, medium and low.
- R11: No grant is issued at a clock edge where `reti` is high. A request that is still pending is granted one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | N | Request lines |
| irq_en | input | N | Per-line enable |
| irq_lvl | input | 2*N | Two-bit level code per line |
| nmi_req | input | 1 | Non-maskable request |
| lvl_en | input | 3 | Level enables: low, medium, high |
| glb_en | input | 1 | Global enable for maskable requests |
| rr_en | input | 1 | Rotating priority at low level |
| reti | input | 1 | Return-from-interrupt pulse |
| take | output | 1 | One-cycle take-interrupt strobe |
| vec_addr | output | AW | Word address of granted vector |
| in_service | output | 4 | In-service flags: low, medium, high, non-maskable |

## Verification
The hardest state to reach is deep nesting: three or four flags set at once, followed by a series of returns that must peel them off in the right order. The stimulus builds this up one step at a time. It grants a low line, then raises a medium and then a high line while lower-level requests stay pending. A non-maskable request then lands on top of an active high handler. Rotation is reached by holding three low lines pending and cycling grant and return several times, so that the search wraps past the last line. The stored line is then dropped with a single cycle of `rr_en` low.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int N      = 16,
  parameter int STRIDE = 2,
  parameter int AW     = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   irq_req,
  input  logic [N-1:0]   irq_en,
  input  logic [2*N-1:0] irq_lvl,
  input  logic           nmi_req,
  input  logic [2:0]     lvl_en,
  input  logic           glb_en,
  input  logic           rr_en,
  input  logic           reti,
  output logic           take,
  output logic [AW-1:0]  vec_addr,
  output logic [3:0]     in_service
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam logic [1:0] LV_LO = 2'd1, LV_MD = 2'd2, LV_HI = 2'd3;

  function automatic logic [IW-1:0] low_idx(input logic [N-1:0] v);
    low_idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (v[i]) low_idx = IW'(i);
  endfunction

  logic [N-1:0]  pend_lo, pend_md, pend_hi, rr_above, lo_masked;
  logic [IW-1:0] rr_last, lo_pick, gidx;
  logic          rr_vld, gnt;
  logic [1:0]    gbit;
  logic [2:0]    cur;
  logic [AW-1:0] gaddr;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      pend_lo[i]  = irq_req[i] & irq_en[i] & (irq_lvl[2*i +: 2] == LV_LO);
      pend_md[i]  = irq_req[i] & irq_en[i] & (irq_lvl[2*i +: 2] == LV_MD);
      pend_hi[i]  = irq_req[i] & irq_en[i] & (irq_lvl[2*i +: 2] == LV_HI);
      rr_above[i] = rr_en & rr_vld & (IW'(i) > rr_last);
    end
  end

  assign lo_masked = pend_lo & rr_above;
  assign lo_pick   = (|lo_masked) ? low_idx(lo_masked) : low_idx(pend_lo);

  assign cur = in_service[3] ? 3'd4 : in_service[2] ? 3'd3 :
               in_service[1] ? 3'd2 : in_service[0] ? 3'd1 : 3'd0;

  always_comb begin
    gnt   = 1'b0;
    gbit  = 2'd0;
    gidx  = '0;
    gaddr = '0;
    if (!reti) begin
      if (nmi_req && !in_service[3]) begin
        gnt = 1'b1; gbit = 2'd3; gaddr = AW'(STRIDE);
      end else if (glb_en) begin
        if ((|pend_hi) && lvl_en[2] && cur < 3'd3) begin
          gnt = 1'b1; gbit = 2'd2; gidx = low_idx(pend_hi);
        end else if ((|pend_md) && lvl_en[1] && cur < 3'd2) begin
          gnt = 1'b1; gbit = 2'd1; gidx = low_idx(pend_md);
        end else if ((|pend_lo) && lvl_en[0] && cur < 3'd1) begin
          gnt = 1'b1; gbit = 2'd0; gidx = lo_pick;
        end
        gaddr = AW'((32'(gidx) + 32'd2) * STRIDE);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take       <= 1'b0;
      vec_addr   <= '0;
      in_service <= '0;
      rr_last    <= '0;
      rr_vld     <= 1'b0;
    end else begin
      take <= gnt;
      if (gnt) begin
        vec_addr         <= gaddr;
        in_service[gbit] <= 1'b1;
        if (gbit == 2'd0) begin
          rr_last <= gidx;
          rr_vld  <= 1'b1;
        end
      end
      if (reti) begin
        if (in_service[3])      in_service[3] <= 1'b0;
        else if (in_service[2]) in_service[2] <= 1'b0;
        else if (in_service[1]) in_service[1] <= 1'b0;
        else if (in_service[0]) in_service[0] <= 1'b0;
      end
      if (!rr_en) rr_vld <= 1'b0;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int STRIDE = 2,
  parameter int AW     = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          nmi_req,
  input logic          glb_en,
  input logic          reti,
  input logic          take,
  input logic [AW-1:0] vec_addr,
  input logic [3:0]    in_service
);
  // R9
  grant_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $countones(in_service) == $countones($past(in_service)) + 1);

  // R10
  reti_clears_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && |in_service) |=> $countones(in_service) == $countones($past(in_service)) - 1);

  // R11
  reti_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reti |=> !take);

  // R7
  nmi_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_req && !in_service[3] && !reti) |=> (take && vec_addr == AW'(STRIDE)));

  // R2
  masked_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en && !nmi_req) |=> !take);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.STRIDE(STRIDE), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .glb_en(glb_en), .reti(reti),
  .take(take), .vec_addr(vec_addr), .in_service(in_service)
);

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;
  localparam int AW = 8;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [N-1:0]   irq_req, irq_en;
  logic [2*N-1:0] irq_lvl;
  logic           nmi_req, glb_en, rr_en, reti;
  logic [2:0]     lvl_en;
  logic           take;
  logic [AW-1:0]  vec_addr;
  logic [3:0]     in_service;

  int total = 0;
  int bad = 0;

  prio_irq_ctrl #(.N(N), .STRIDE(2), .AW(AW)) u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en),
    .irq_lvl(irq_lvl), .nmi_req(nmi_req), .lvl_en(lvl_en), .glb_en(glb_en),
    .rr_en(rr_en), .reti(reti), .take(take), .vec_addr(vec_addr),
    .in_service(in_service)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_in();
    irq_req = '0; irq_en = '0; irq_lvl = '0; nmi_req = 0;
    lvl_en = 3'b111; glb_en = 1; rr_en = 0; reti = 0;
  endtask

  task automatic set_line(input int i, input int lvl);
    irq_en[i] = 1'b1;
    irq_lvl[2*i +: 2] = 2'(lvl);
    irq_req[i] = 1'b1;
  endtask

  task automatic do_reti();
    reti = 1; step(); reti = 0;
  endtask

  task automatic t_reset();
    clear_in();
    rst_n = 0;
    set_line(3, 2);
    step(); step();
    check(take, 0, "R1 take in reset");
    check(in_service, 0, "R1 flags in reset");
    irq_req = '0;
    rst_n = 1;
    step();
    check(take, 0, "R1 take after reset");
    check(in_service, 0, "R1 flags after reset");
  endtask

  task automatic t_gating();
    clear_in();
    set_line(4, 1); glb_en = 0; step();
    check(take, 0, "R2 global disable");
    glb_en = 1; lvl_en = 3'b110; step();
    check(take, 0, "R2 level disable");
    lvl_en = 3'b111; irq_en[4] = 0; step();
    check(take, 0, "R2 line disable");
    irq_en[4] = 1; irq_lvl[9:8] = 2'd0; step();
    check(take, 0, "R2 level off");
    check(in_service, 0, "R2 no flag set");
  endtask

  task automatic t_fixed();
    clear_in();
    set_line(4, 2); set_line(2, 2);
    step();
    check(take, 1, "R4 take");
    check(vec_addr, 8, "R4 R8 lowest medium line 2");
    check(in_service, 4'b0010, "R9 medium flag");
    irq_req = '0;
    step();
    check(take, 0, "R9 one-cycle pulse");
    do_reti();
    check(in_service, 0, "R10 flag cleared");
  endtask

  task automatic t_preempt();
    clear_in();
    set_line(0, 1); step();
    check(vec_addr, 4, "R8 line 0 address");
    check(in_service, 4'b0001, "R3 low active");
    set_line(7, 1); step();
    check(take, 0, "R3 equal level waits");
    set_line(5, 2); step();
    check(take, 1, "R3 medium preempts");
    check(vec_addr, 14, "R3 medium vector");
    set_line(3, 2); step();
    check(take, 0, "R3 medium waits under medium");
    set_line(9, 3); step();
    check(vec_addr, 22, "R3 high preempts");
    check(in_service, 4'b0111, "R3 three levels active");
    irq_req = '0; step();
    do_reti();
    check(in_service, 4'b0011, "R10 high cleared first");
    do_reti(); do_reti();
    check(in_service, 0, "R10 all cleared");
  endtask

  task automatic t_nmi();
    clear_in();
    set_line(6, 3); step();
    check(in_service, 4'b0100, "R7 high active");
    irq_req = '0; glb_en = 0; lvl_en = 3'b000; nmi_req = 1;
    step();
    check(take, 1, "R7 nmi take");
    check(vec_addr, 2, "R7 nmi vector");
    check(in_service, 4'b1100, "R7 nmi above high");
    step();
    check(take, 0, "R7 nmi no repeat");
    nmi_req = 0;
    do_reti();
    check(in_service, 4'b0100, "R10 nmi cleared first");
    do_reti();
    check(in_service, 0, "R10 high cleared");
  endtask

  task automatic t_rr();
    clear_in();
    rr_en = 1;
    set_line(1, 1); set_line(3, 1); set_line(5, 1);
    step();
    check(vec_addr, 6, "R5 first low line 1");
    do_reti(); step();
    check(vec_addr, 10, "R5 rotate to line 3");
    do_reti(); step();
    check(vec_addr, 14, "R5 rotate to line 5");
    do_reti(); step();
    check(vec_addr, 6, "R5 wrap to line 1");
    rr_en = 0;
    do_reti();
    rr_en = 1;
    step();
    check(take, 1, "R6 take after clear");
    check(vec_addr, 6, "R6 fixed order restored");
    irq_req = '0; step();
    do_reti();
  endtask

  task automatic t_reti_block();
    clear_in();
    set_line(8, 1);
    reti = 1; step(); reti = 0;
    check(take, 0, "R11 no grant with reti");
    step();
    check(take, 1, "R11 grant one edge later");
    check(vec_addr, 20, "R11 vector line 8");
    irq_req = '0; step();
    do_reti();
  endtask

  initial begin
    t_reset();
    t_gating();
    t_fixed();
    t_preempt();
    t_nmi();
    t_rr();
    t_reti_block();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    total++; bad++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule